// File: doc/BRIEF.md
# Gated Power-of-Two Clock Prescaler

This block takes a free-running core clock and produces a square wave whose half period is 2^x core cycles, where x comes from a 4-bit divide code. The core clock stands for the master oscillator at twice its rate, so one master period is two core cycles and the output frequency is the master frequency divided by 2^x. The output is 50% duty. It goes to a pad through a data value and a separate drive enable.

Two control inputs decide whether the wave reaches the pad. An output-enable input gates only the pad driver. A power-down input, after a deglitch delay, stops the divider and reruns the start-up hold-off. Every switch on or off happens at a point where the wave is low, so no shortened pulse appears. A switch-on always restarts the divider, which fixes the latency from the enable edge to the first rising edge. When the output is off, a park bit selects between driven low and high impedance.

Top module: `pscl_gated_clk`

## Requirements
- R1: With divide code x in 0..8 and the output enabled, clk_out is high for exactly 2^x core cycles and low for exactly 2^x core cycles.
- R2: Divide codes 9 to 15 behave exactly like code 8: the half period is 256 core cycles.
- R3: After reset release, with oe_pin and pdn_n high, the first rising edge of clk_out is sampled after exactly STARTUP_CYCLES + 1 + 2^x core clock edges, and never earlier than STARTUP_CYCLES edges.
- R4: With the hold-off complete and the output off, a rising oe_pin gives the first clk_out rise exactly 3 + 2^x edges later, whatever the divider phase, and switches on with clk_out low. OE alone never reruns the hold-off.
- R5: Switching off occurs only after a complete low half period. Every high pulse of clk_out lasts the full 2^x cycles, and clk_out stays low once the output is off.
- R6: While the output is off, clk_out is 0 and drive_en equals park_low (1 = driven low, 0 = high impedance). While the output is on, drive_en is 1. During reset both outputs are 0.
- R7: A low level on pdn_n that lasts fewer than DEGLITCH_CYCLES + 4·2^x core cycles is ignored. A longer one shuts the output and the divider down.
- R8: After a power-down ends, the hold-off reruns: the first clk_out rise comes exactly STARTUP_CYCLES + 4 + 2^x edges after pdn_n rises.
- R9: A change of divide code restarts the divider: clk_out drops to 0 on the next edge and first rises 1 + 2^x edges after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the master oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| oe_pin | input | 1 | Output enable, asynchronous, high = drive the wave |
| pdn_n | input | 1 | Run request, asynchronous, low = power down |
| div_code | input | 4 | Divide exponent x, values above 8 saturate |
| park_low | input | 1 | Off-state level: 1 driven low, 0 high impedance |
| clk_out | output | 1 | Divided clock value for the pad |
| drive_en | output | 1 | Pad driver enable |

## Verification
The hardest state to reach is a power-down request that lands while the wave is mid-high. The shutdown must then wait for the next low half before it parks the pad. The bench reaches this with pdn_n pulses sized just under and well over the deglitch threshold at a mid-range divide code. It times the return to first edge exactly, and a pulse-width monitor flags any shortened high pulse. Sweeping all sixteen codes while the output runs covers saturation and the restart on a code change.

// File: rtl/pscl_pkg.sv
package pscl_pkg;
  localparam int CODE_W    = 4;
  localparam int MAX_SHIFT = 8;

  function automatic logic [CODE_W-1:0] sat_code(input logic [CODE_W-1:0] code);
    if (code > CODE_W'(MAX_SHIFT)) return CODE_W'(MAX_SHIFT);
    return code;
  endfunction
endpackage

// File: rtl/pscl_sync2.sv
module pscl_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/pscl_divider.sv
module pscl_divider
  import pscl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] x_cur,
  output logic              wave_nxt,
  output logic              rise_evt
);
  localparam int CNT_W = MAX_SHIFT;

  logic [CODE_W-1:0] x_q, x_sat;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    lim;
  logic              wave_q, tick, clr, chg;

  assign x_sat = sat_code(code);
  assign chg   = (x_sat != x_q);
  assign clr   = hold | restart | chg;
  assign lim   = ((CNT_W+1)'(1) << x_q) - (CNT_W+1)'(1);
  assign tick  = ({1'b0, cnt_q} == lim);

  always_comb begin
    if (clr)       wave_nxt = 1'b0;
    else if (tick) wave_nxt = ~wave_q;
    else           wave_nxt = wave_q;
  end

  assign rise_evt = tick & ~wave_q & ~clr;
  assign x_cur    = x_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      x_q    <= x_sat;
      wave_q <= wave_nxt;
      if (clr || tick) cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pscl_power.sv
module pscl_power
  import pscl_pkg::*;
#(
  parameter int STARTUP_CYCLES  = 1024,
  parameter int DEGLITCH_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_s,
  input  logic              gate,
  input  logic [CODE_W-1:0] x_cur,
  output logic              pd_req,
  output logic              pd_active,
  output logic              ready
);
  localparam int PD_W = $clog2(DEGLITCH_CYCLES + (4 << MAX_SHIFT) + 1);
  localparam int SU_W = $clog2(STARTUP_CYCLES + 1);

  logic [PD_W-1:0] pd_cnt, pd_lim;
  logic [SU_W-1:0] su_cnt;

  assign pd_lim    = PD_W'(DEGLITCH_CYCLES) + (PD_W'(4) << x_cur);
  assign pd_req    = (pd_cnt >= pd_lim);
  assign pd_active = pd_req & ~gate;
  assign ready     = (su_cnt == SU_W'(STARTUP_CYCLES));

  always_ff @(posedge clk) begin
    if (rst)                  pd_cnt <= '0;
    else if (pdn_s)           pd_cnt <= '0;
    else if (pd_cnt < pd_lim) pd_cnt <= pd_cnt + PD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)            su_cnt <= '0;
    else if (pd_active) su_cnt <= '0;
    else if (!ready)    su_cnt <= su_cnt + SU_W'(1);
  end
endmodule

// File: rtl/pscl_gated_clk.sv
module pscl_gated_clk
  import pscl_pkg::*;
#(
  parameter int STARTUP_CYCLES  = 1024,
  parameter int DEGLITCH_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_pin,
  input  logic              pdn_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              park_low,
  output logic              clk_out,
  output logic              drive_en
);
  logic [1:0]        sync_q;
  logic              oe_s, pdn_s;
  logic              gate_q, gate_n, want_on, start;
  logic              wave_nxt, rise_evt;
  logic              pd_req, pd_active, ready;
  logic [CODE_W-1:0] x_cur;

  pscl_sync2 #(.WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pdn_n, oe_pin}),
    .q   (sync_q)
  );
  assign oe_s  = sync_q[0];
  assign pdn_s = sync_q[1];

  pscl_divider u_div (
    .clk      (clk),
    .rst      (rst),
    .hold     (pd_active),
    .restart  (start),
    .code     (div_code),
    .x_cur    (x_cur),
    .wave_nxt (wave_nxt),
    .rise_evt (rise_evt)
  );

  pscl_power #(
    .STARTUP_CYCLES  (STARTUP_CYCLES),
    .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
  ) u_pwr (
    .clk       (clk),
    .rst       (rst),
    .pdn_s     (pdn_s),
    .gate      (gate_q),
    .x_cur     (x_cur),
    .pd_req    (pd_req),
    .pd_active (pd_active),
    .ready     (ready)
  );

  // Switch on restarts the divider (wave low); switch off waits for the
  // end of a low half so the last high pulse is always complete.
  assign want_on = ready & oe_s & ~pd_req;
  assign start   = ~gate_q & want_on;

  always_comb begin
    if (start)         gate_n = 1'b1;
    else if (rise_evt) gate_n = want_on;
    else               gate_n = gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b0;
      clk_out  <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      gate_q   <= gate_n;
      clk_out  <= wave_nxt & gate_n;
      drive_en <= gate_n | park_low;
    end
  end
endmodule

// File: rtl/pscl_gated_clk_chk.sv
module pscl_gated_clk_chk #(
  parameter int STARTUP_CYCLES = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       park_low,
  input logic       clk_out,
  input logic       drive_en,
  input logic       gate_q,
  input logic       pd_active,
  input logic [3:0] x_cur
);
  localparam int SR_W = $clog2(STARTUP_CYCLES + 2);
  logic [SR_W-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != SR_W'(STARTUP_CYCLES + 1)) since_rst <= since_rst + SR_W'(1);
  end

  p_code_sat_r2: assert property (@(posedge clk) disable iff (rst)
    x_cur <= 4'd8);

  p_holdoff_r3: assert property (@(posedge clk) disable iff (rst)
    clk_out |-> since_rst >= SR_W'(STARTUP_CYCLES));

  p_on_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> !clk_out);

  p_off_low_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_q) |-> (!clk_out && !$past(clk_out)));

  p_park_r6: assert property (@(posedge clk) disable iff (rst)
    !gate_q |-> (!clk_out && drive_en == $past(park_low)));

  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    pd_active |-> (!clk_out && !gate_q));
endmodule

bind pscl_gated_clk pscl_gated_clk_chk #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .park_low  (park_low),
  .clk_out   (clk_out),
  .drive_en  (drive_en),
  .gate_q    (gate_q),
  .pd_active (pd_active),
  .x_cur     (x_cur)
);

// File: tb/pscl_gated_clk_bench.sv
`timescale 1ns/1ps
module pscl_gated_clk_bench;
  localparam int STARTUP  = 1024;
  localparam int DEGLITCH = 20;

  logic clk = 1'b0;
  logic rst, oe_pin, pdn_n, park_low;
  logic [3:0] div_code;
  logic clk_out, drive_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;
  int mon_exp = 1;
  int hrun = 0;

  always #2.5 clk = ~clk;

  pscl_gated_clk #(.STARTUP_CYCLES(STARTUP), .DEGLITCH_CYCLES(DEGLITCH)) u_pscl_gated_clk (
    .clk(clk), .rst(rst), .oe_pin(oe_pin), .pdn_n(pdn_n), .div_code(div_code),
    .park_low(park_low), .clk_out(clk_out), .drive_en(drive_en));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_to_rise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clk_out && n < 5000);
  endtask

  task automatic measure(output int h, output int l);
    int g = 0;
    while (clk_out && g < 2000) begin step(1); g++; end
    while (!clk_out && g < 4000) begin step(1); g++; end
    h = 0;
    while (clk_out && h < 2000) begin step(1); h++; end
    l = 0;
    while (!clk_out && l < 2000) begin step(1); l++; end
  endtask

  task automatic mon_start(input int x);
    while (clk_out) step(1);
    mon_exp = 1 << x;
    hrun = 0;
    mon_on = 1;
  endtask

  // R5: every completed high pulse lasts a full half period
  always @(negedge clk) begin
    if (clk_out) hrun++;
    else begin
      if (mon_on && hrun != 0) check(hrun == mon_exp, "R5 high pulse width", hrun, mon_exp);
      hrun = 0;
    end
  end

  function automatic int half_of(input int c);
    return 1 << ((c > 8) ? 8 : c);
  endfunction

  initial begin
    int n, h, l, lowrun, maxlow;
    bit drv_drop;
    rst = 1; oe_pin = 1; pdn_n = 1; park_low = 0; div_code = 4'd3;
    step(4);
    check(clk_out == 0, "R6 reset clk_out", clk_out, 0);
    check(drive_en == 0, "R6 reset drive_en", drive_en, 0);
    rst = 0;
    edges_to_rise(n);
    check(n == STARTUP + 1 + 8, "R3 first edge after reset", n, STARTUP + 9);

    // R1 / R2 / R9 sweep over all codes
    for (int c = 0; c < 16; c++) begin
      div_code = 4'(c);
      if (c <= 8) begin
        edges_to_rise(n);
        check(n == 1 + half_of(c), "R9 restart on code change", n, 1 + half_of(c));
      end
      measure(h, l);
      check(h == half_of(c), (c > 8) ? "R2 high half" : "R1 high half", h, half_of(c));
      check(l == half_of(c), (c > 8) ? "R2 low half" : "R1 low half", l, half_of(c));
    end

    // R4 / R5 / R6 enable and disable at several codes
    for (int k = 0; k < 3; k++) begin
      int x = (k == 0) ? 2 : ((k == 1) ? 0 : 5);
      div_code = 4'(x);
      step(3);
      mon_start(x);
      step(k * 3 + 1);
      oe_pin = 0;
      step(3 * (1 << x) + 4);
      mon_on = 0;
      n = 0;
      for (int i = 0; i < 20; i++) begin step(1); n += clk_out; end
      check(n == 0, "R5 output stays low when off", n, 0);
      check(drive_en == 0, "R6 high-Z when off", drive_en, 0);
      park_low = 1;
      step(2);
      check(drive_en == 1 && clk_out == 0, "R6 driven low when off", drive_en, 1);
      park_low = 0;
      step(2 + k);
      oe_pin = 1;
      edges_to_rise(n);
      check(n == 3 + (1 << x), "R4 enable latency", n, 3 + (1 << x));
      check(drive_en == 1, "R6 drive on while running", drive_en, 1);
    end

    // R7 short power-down pulse ignored (x = 2, threshold 36)
    div_code = 4'd2;
    step(3);
    mon_start(2);
    pdn_n = 0;
    step(DEGLITCH + 16 - 3);
    pdn_n = 1;
    maxlow = 0; lowrun = 0; drv_drop = 0;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (!drive_en) drv_drop = 1;
      if (clk_out) lowrun = 0; else begin lowrun++; if (lowrun > maxlow) maxlow = lowrun; end
    end
    check(maxlow <= 4, "R7 short pulse ignored (low run)", maxlow, 4);
    check(!drv_drop, "R7 short pulse ignored (drive)", drv_drop, 0);

    // R7 / R8 long pulse shuts down, hold-off reruns
    pdn_n = 0;
    step(55);
    check(clk_out == 0 && drive_en == 0, "R7 long pulse shuts down", drive_en, 0);
    step(5);
    mon_on = 0;
    pdn_n = 1;
    edges_to_rise(n);
    check(n == STARTUP + 4 + 4, "R8 hold-off after power-down", n, STARTUP + 8);

    // R6 parked low during power-down
    park_low = 1;
    pdn_n = 0;
    step(60);
    check(drive_en == 1 && clk_out == 0, "R6 park low in power-down", drive_en, 1);
    pdn_n = 1;
    step(5);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule